// File: doc/BRIEF.md
# NAND Page Parity Code Generator

This block watches the byte stream that moves between a controller and a NAND page and builds a Hamming-style parity code over it. The code is used later to find and repair single-bit errors. A page is split into regions of 512 bytes. Each region has its own result register, and up to four regions run back to back, so one 2048-byte page is covered in a single pass. A small page uses only the first region.

For each region the block keeps 24 parity bits, arranged as twelve odd/even pairs. Three pairs look at the bit position inside a byte, over groups of 1, 2 and 4 bits. Nine pairs look at the byte address, over groups of 8 to 2048 bits. Software prepares a pass by reading every region register; each read returns the value and clears that register. A one-cycle start pulse then arms accumulation. The block steps to the next region on its own after every 512th byte. Once the last configured region is full, it drops its busy bit and raises a done flag.

A read returns the raw 32-bit word. It also returns the same result packed into three bytes, ready to be stored in the spare area. Consecutive regions therefore give consecutive three-byte groups, twelve bytes for a full page.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset, busy and done are 0 and every region register reads 0.
- R2: A start pulse sets busy and clears done. It resets the region index to 0 and the byte count to 0, and latches the last region index from `cfg_last_i` (0 means one region, 3 means four). A byte strobe in the start cycle is not counted.
- R3: Bit-level pairs, for k = 0, 1, 2: the odd parity is the XOR of all data bits whose bit position has bit k set, and the even parity is the XOR of the data bits whose bit position has bit k clear. Odd pair k is stored at word bit k and even pair k at word bit 16+k.
- R4: Address-level pairs, for j = 0..8: the odd parity is the XOR of every bit of the bytes whose in-region address has bit j set, and the even parity covers the bytes where it is clear. These are stored at word bits 3+j (odd) and 19+j (even). Word bits [15:12] and [31:28] read 0.
- R5: A byte is accumulated only on a cycle where `strb_i` is 1 and busy is 1. Idle cycles and strobes while not busy leave every region unchanged.
- R6: After the 512th strobed byte of a region that is not the last, accumulation moves to the next region, with the in-region address starting again at 0.
- R7: On the 512th byte of the last configured region, busy falls and done rises on the next cycle. Later bytes change no region.
- R8: Regions beyond the configured last region are never written during a pass.
- R9: A read (`rd_en_i`) returns the selected region's current word in the same cycle and clears that register at the clock edge. If a byte is accumulated into the same region in that cycle, the register then holds only that byte's contribution.
- R10: Packed code: byte 0 = word[7:0], byte 1 = word[23:16], byte 2 = {word[27:24], word[11:8]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that arms a new pass |
| cfg_last_i | input | 2 | Index of the last region in the pass, sampled at start |
| strb_i | input | 1 | Byte strobe on the data stream |
| data_i | input | 8 | Data byte |
| rd_en_i | input | 1 | Read request; clears the selected region |
| rd_sel_i | input | 2 | Region to read |
| rd_word_o | output | 32 | Raw parity word of the selected region |
| rd_b0_o | output | 8 | Packed code byte 0 |
| rd_b1_o | output | 8 | Packed code byte 1 |
| rd_b2_o | output | 8 | Packed code byte 2 |
| busy_o | output | 1 | Accumulation armed |
| done_o | output | 1 | Last region completed |

## Verification
The embedded assertions check the sequencing rules on every cycle:
- the effect of a start pulse;
- the region step at a 512-byte boundary;
- the finish into done;
- done never coexisting with busy;
- region storage holding still when nothing accumulates or clears;
- a read clearing its register.

The values of the parity bits, their placement in the word and the byte packing can only be shown by the bench's scenarios. These compare each region against an independent per-bit model over pseudo-random buffers, idle gaps and hand-computed single-byte cases. The scenarios also cover the overlap of a read with accumulation into the same region.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;
    localparam int LANE_W = 3;   // log2 of BYTE_W: bit-position index width

    // Pack a raw parity word into the three stored code bytes.
    function automatic logic [23:0] pack_code(input logic [WORD_W-1:0] w);
        logic [7:0] b0, b1, b2;
        b0 = w[7:0];
        b1 = w[23:16];
        b2 = {w[27:24], w[11:8]};
        return {b2, b1, b0};
    endfunction

    // Mask of the bit positions within a byte whose index has bit k set.
    function automatic logic [BYTE_W-1:0] lane_mask(input int k);
        logic [BYTE_W-1:0] m;
        for (int i = 0; i < BYTE_W; i++) begin
            m[i] = ((i >> k) & 1) == 1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_byte_par.sv
module ecc_byte_par
    import nand_ecc_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAIRS  = LANE_W + ADDR_W
) (
    input  logic [BYTE_W-1:0] data_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [PAIRS-1:0]  odd_o,
    output logic [PAIRS-1:0]  even_o
);

    logic byte_par;
    assign byte_par = ^data_i;

    // Bit-level groups: split the byte by bit k of the bit position.
    for (genvar k = 0; k < LANE_W; k++) begin : g_lane
        localparam logic [BYTE_W-1:0] MASK = lane_mask(k);
        assign odd_o[k]  = ^(data_i & MASK);
        assign even_o[k] = ^(data_i & ~MASK);
    end

    // Address-level groups: the whole byte counts toward one side of each pair.
    for (genvar j = 0; j < ADDR_W; j++) begin : g_addr
        assign odd_o[LANE_W+j]  = byte_par & addr_i[j];
        assign even_o[LANE_W+j] = byte_par & ~addr_i[j];
    end

endmodule

// File: rtl/ecc_region_bank.sv
module ecc_region_bank
    import nand_ecc_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int PAIRS       = 12,
    parameter int RIDX_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en_i,
    input  logic [RIDX_W-1:0] acc_sel_i,
    input  logic [PAIRS-1:0]  acc_odd_i,
    input  logic [PAIRS-1:0]  acc_even_i,
    input  logic              clr_en_i,
    input  logic [RIDX_W-1:0] clr_sel_i,
    input  logic [RIDX_W-1:0] rd_sel_i,
    output logic [WORD_W-1:0] rd_word_o
);

    localparam int PAD_W = HALF_W - PAIRS;

    typedef struct packed {
        logic [PAIRS-1:0] odd;
        logic [PAIRS-1:0] even;
    } par_t;

    par_t regs_d [NUM_REGIONS];
    par_t regs_q [NUM_REGIONS];

    always_comb begin
        for (int r = 0; r < NUM_REGIONS; r++) begin
            regs_d[r] = regs_q[r];
            if (clr_en_i && clr_sel_i == RIDX_W'(r)) begin
                regs_d[r] = '0;
            end
            if (acc_en_i && acc_sel_i == RIDX_W'(r)) begin
                regs_d[r].odd  = regs_d[r].odd  ^ acc_odd_i;
                regs_d[r].even = regs_d[r].even ^ acc_even_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGIONS; r++) begin
                regs_q[r] <= '0;
            end
        end else begin
            for (int r = 0; r < NUM_REGIONS; r++) begin
                regs_q[r] <= regs_d[r];
            end
        end
    end

    assign rd_word_o = {{PAD_W{1'b0}}, regs_q[rd_sel_i].even,
                        {PAD_W{1'b0}}, regs_q[rd_sel_i].odd};

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en_i && !clr_en_i) |=> $stable(regs_q[rd_sel_i])) // R5
        else $error("region changed without accumulate or clear");

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && !(acc_en_i && acc_sel_i == clr_sel_i))
            |=> regs_q[$past(clr_sel_i)] == '0) // R9
        else $error("read did not clear region");

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
    import nand_ecc_pkg::*;
#(
    parameter int REGION_BYTES = 512,
    parameter int NUM_REGIONS  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [1:0]  cfg_last_i,
    input  logic        strb_i,
    input  logic [7:0]  data_i,
    input  logic        rd_en_i,
    input  logic [1:0]  rd_sel_i,
    output logic [31:0] rd_word_o,
    output logic [7:0]  rd_b0_o,
    output logic [7:0]  rd_b1_o,
    output logic [7:0]  rd_b2_o,
    output logic        busy_o,
    output logic        done_o
);

    localparam int ADDR_W = $clog2(REGION_BYTES);
    localparam int PAIRS  = LANE_W + ADDR_W;
    localparam int RIDX_W = 2;
    localparam logic [ADDR_W-1:0] CNT_MAX = ADDR_W'(REGION_BYTES - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [RIDX_W-1:0] last;
        logic [RIDX_W-1:0] rgn;
        logic [ADDR_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic acc_en;
    logic [PAIRS-1:0] c_odd, c_even;
    logic [23:0] packed_code;

    assign acc_en = s_q.busy && strb_i && !start_i;

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.done = 1'b0;
            s_d.last = cfg_last_i;
            s_d.rgn  = '0;
            s_d.cnt  = '0;
        end else if (acc_en) begin
            if (s_q.cnt == CNT_MAX) begin
                s_d.cnt = '0;
                if (s_q.rgn == s_q.last) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.rgn = s_q.rgn + 1'b1;
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    ecc_byte_par #(.ADDR_W(ADDR_W), .PAIRS(PAIRS)) u_par (
        .data_i (data_i),
        .addr_i (s_q.cnt),
        .odd_o  (c_odd),
        .even_o (c_even)
    );

    ecc_region_bank #(.NUM_REGIONS(NUM_REGIONS), .PAIRS(PAIRS), .RIDX_W(RIDX_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en_i   (acc_en),
        .acc_sel_i  (s_q.rgn),
        .acc_odd_i  (c_odd),
        .acc_even_i (c_even),
        .clr_en_i   (rd_en_i),
        .clr_sel_i  (rd_sel_i),
        .rd_sel_i   (rd_sel_i),
        .rd_word_o  (rd_word_o)
    );

    assign packed_code = pack_code(rd_word_o);
    assign rd_b0_o     = packed_code[7:0];
    assign rd_b1_o     = packed_code[15:8];
    assign rd_b2_o     = packed_code[23:16];
    assign busy_o      = s_q.busy;
    assign done_o      = s_q.done;

    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && !done_o && s_q.cnt == '0 && s_q.rgn == '0)) // R2
        else $error("start did not arm");

    AST_REGION_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && s_q.cnt == CNT_MAX && s_q.rgn != s_q.last)
            |=> (s_q.rgn == $past(s_q.rgn) + 1'b1 && s_q.cnt == '0 && busy_o)) // R6
        else $error("region did not advance");

    AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && s_q.cnt == CNT_MAX && s_q.rgn == s_q.last) |=> (!busy_o && done_o)) // R7
        else $error("pass did not finish");

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o) // R7
        else $error("done while busy");

    AST_RGN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> s_q.rgn <= s_q.last) // R8
        else $error("region past configured last");

endmodule

// File: tb/tb_nand_ecc_gen.sv
module tb_nand_ecc_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  cfg_last_i = '0;
    logic        strb_i = 1'b0;
    logic [7:0]  data_i = '0;
    logic        rd_en_i = 1'b0;
    logic [1:0]  rd_sel_i = '0;
    logic [31:0] rd_word_o;
    logic [7:0]  rd_b0_o, rd_b1_o, rd_b2_o;
    logic        busy_o, done_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [7:0] pg [0:2047];

    always #5 clk = ~clk;

    nand_ecc_gen dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_last_i(cfg_last_i),
        .strb_i(strb_i), .data_i(data_i), .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i),
        .rd_word_o(rd_word_o), .rd_b0_o(rd_b0_o), .rd_b1_o(rd_b1_o), .rd_b2_o(rd_b2_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    // Stimulus vectors: {seed, last region, idle-gap length}
    localparam int NV = 6;
    localparam logic [35:0] VEC [NV] = '{
        {32'h1234_5678, 2'd3, 2'd0},
        {32'hCAFE_0001, 2'd0, 2'd0},
        {32'h0BAD_F00D, 2'd1, 2'd1},
        {32'h7777_1111, 2'd3, 2'd2},
        {32'hDEAD_0042, 2'd2, 2'd3},
        {32'h0000_0F0F, 2'd3, 2'd1}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<=150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Reference: per-bit walk of the region, following R3 and R4.
    function automatic logic [31:0] model(input int base);
        logic [11:0] od = '0;
        logic [11:0] ev = '0;
        for (int a = 0; a < 512; a++) begin
            for (int i = 0; i < 8; i++) begin
                if (pg[base+a][i]) begin
                    for (int k = 0; k < 3; k++) begin
                        if ((i >> k) & 1) od[k] = ~od[k]; else ev[k] = ~ev[k];
                    end
                    for (int j = 0; j < 9; j++) begin
                        if ((a >> j) & 1) od[3+j] = ~od[3+j]; else ev[3+j] = ~ev[3+j];
                    end
                end
            end
        end
        return {4'h0, ev, 4'h0, od};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [1:0] last);
        @(negedge clk);
        start_i = 1'b1;
        cfg_last_i = last;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Stream n bytes from pg starting at base; optional idle cycles between bytes.
    task automatic stream(input int base, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            strb_i = 1'b1;
            data_i = pg[base+i];
            @(negedge clk);
            strb_i = 1'b0;
            data_i = 8'hA5;
            if (gap != 0 && (i % (gap + 2)) == 0) begin
                repeat (gap) @(negedge clk);
            end
        end
    endtask

    // Read a region (clears it). Called at a negedge.
    task automatic rd_region(input logic [1:0] r, output logic [31:0] w, output logic [23:0] code);
        rd_en_i = 1'b1;
        rd_sel_i = r;
        #1;
        w = rd_word_o;
        code = {rd_b2_o, rd_b1_o, rd_b0_o};
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic peek(input logic [1:0] r, output logic [31:0] w);
        rd_sel_i = r;
        #1;
        w = rd_word_o;
    endtask

    initial begin
        logic [31:0] w, exp, seed;
        logic [23:0] code;
        logic [1:0] last;
        int gap;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", {31'b0, busy_o}, 32'd0);
        check("R1 done", {31'b0, done_o}, 32'd0);
        for (int r = 0; r < 4; r++) begin
            peek(2'(r), w);
            check("R1 region zero", w, 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R5: strobes while not busy change nothing
        for (int i = 0; i < 2048; i++) pg[i] = 8'hFF ^ 8'(i);
        stream(0, 20, 0);
        peek(2'd0, w);
        check("R5 idle strobes ignored", w, 32'd0);

        // Vector table: random pages, varied region counts and gaps
        for (int v = 0; v < NV; v++) begin
            seed = VEC[v][35:4];
            last = VEC[v][3:2];
            gap  = int'(VEC[v][1:0]);
            for (int i = 0; i < 2048; i++) begin
                seed = xs(seed);
                pg[i] = seed[7:0];
            end
            do_start(last);
            check("R2 busy after start", {31'b0, busy_o}, 32'd1);
            check("R2 done cleared", {31'b0, done_o}, 32'd0);
            stream(0, (int'(last) + 1) * 512, gap);
            check("R7 busy fallen", {31'b0, busy_o}, 32'd0);
            check("R7 done raised", {31'b0, done_o}, 32'd1);
            stream(0, 8, 0);  // bytes after finish
            for (int r = 0; r < 4; r++) begin
                exp = (r <= int'(last)) ? model(r * 512) : 32'd0;
                rd_region(2'(r), w, code);
                check((r <= int'(last)) ? "R3 R4 R6 region word" : "R8 unused region", w, exp);
                check("R10 packed code", {8'b0, code},
                      {8'b0, exp[27:24], exp[11:8], exp[23:16], exp[7:0]});
            end
            peek(2'd0, w);
            check("R9 read cleared", w, 32'd0);
        end

        // R3 R4 R10: single set bit 0 at address 0
        for (int i = 0; i < 512; i++) pg[i] = 8'h00;
        pg[0] = 8'h01;
        do_start(2'd0);
        stream(0, 512, 0);
        rd_region(2'd0, w, code);
        check("R3 R4 bit0 addr0 word", w, 32'h0FFF_0000);
        check("R10 bit0 addr0 packed", {8'b0, code}, 32'h00F0_FF00);

        // R3 R4 R10: bit 7 at address 511
        pg[0] = 8'h00;
        pg[511] = 8'h80;
        do_start(2'd0);
        stream(0, 512, 0);
        rd_region(2'd0, w, code);
        check("R3 R4 bit7 addr511 word", w, 32'h0000_0FFF);
        check("R10 bit7 addr511 packed", {8'b0, code}, 32'h000F_00FF);

        // R8 R7: one region configured, extra 512 bytes must not reach region 1
        for (int i = 0; i < 1024; i++) pg[i] = 8'(i * 7 + 3);
        do_start(2'd0);
        stream(0, 1024, 0);
        peek(2'd1, w);
        check("R8 region1 untouched", w, 32'd0);
        exp = model(0);
        rd_region(2'd0, w, code);
        check("R7 region0 after extra bytes", w, exp);

        // R2: strobe in the start cycle is not counted
        do_start(2'd0);
        @(negedge clk);
        start_i = 1'b1;
        strb_i = 1'b1;
        data_i = 8'hFF;
        @(negedge clk);
        start_i = 1'b0;
        strb_i = 1'b0;
        stream(0, 512, 0);
        exp = model(0);
        rd_region(2'd0, w, code);
        check("R2 start-cycle byte ignored", w, exp);

        // R9: read overlapping accumulation into the same region
        for (int i = 0; i < 512; i++) pg[i] = 8'(i * 13 + 1);
        do_start(2'd0);
        stream(0, 5, 0);
        for (int i = 0; i < 5; i++) pg[512+i] = pg[i];
        for (int i = 5; i < 512; i++) pg[512+i] = 8'h00;
        exp = model(512);
        rd_en_i = 1'b1;
        rd_sel_i = 2'd0;
        strb_i = 1'b1;
        data_i = pg[5];
        #1;
        check("R9 read returns current", rd_word_o, exp);
        @(negedge clk);
        rd_en_i = 1'b0;
        strb_i = 1'b0;
        stream(6, 506, 0);
        for (int i = 0; i < 5; i++) pg[i] = 8'h00;
        exp = model(0);
        rd_region(2'd0, w, code);
        check("R9 clear plus same-cycle byte", w, exp);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule